// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C master read and write a bank of 8-bit control registers. It listens on SCL and SDA with a faster system clock. It answers to a 7-bit chip address whose two lowest bits come from strap inputs. It pulls SDA low through an output-enable signal and never drives it high. A transfer selects a register with a 16-bit subaddress, sent high byte first.

For a write, the master sends the data bytes straight after the subaddress. For a read, the master issues a repeated start and sends the chip address again with the read direction. The register pointer steps forward after every byte. Only subaddresses inside a window are accepted. The window starts at `BASE_ADDR` and holds `NUM_REGS` registers. At the top of the window a read keeps returning the highest register, while a write is refused.

Each accepted write byte also appears for one system clock cycle on a write port, so that neighbouring logic can follow register changes.

Top module: `i2c_reg_slave`

## Requirements
- R1: The first byte after a start is the chip address. Its bits [7:3] must equal `DEV_ADDR_HI`, bit 2 must equal `addr_pins_i[1]` and bit 1 must equal `addr_pins_i[0]`. Bit 0 is the direction: 0 means the master writes and 1 means the master reads. On a match the target ACKs. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R2: After a write-direction address, the target ACKs the subaddress high byte, then the low byte, then each data byte. Each accepted data byte stores into its register and raises `wr_en_o` for exactly one cycle, with `wr_addr_o` and `wr_data_o` giving the subaddress and the byte.
- R3: Consecutive data bytes in one write go to consecutive subaddresses, including across a carry into the high byte.
- R4: The valid window runs from `BASE_ADDR` up to, but not including, `BASE_ADDR+NUM_REGS`. A subaddress outside it gets no ACK on its low byte, and the target returns to idle. Later bytes of that transfer get no ACK and write nothing.
- R5: In a write, a data byte aimed past the highest subaddress is not stored and raises no write pulse. It is not ACKed, and the target returns to idle.
- R6: After a repeated start and a read-direction address, the target sends bytes MSB first. The first byte comes from the register at the subaddress, and the pointer advances after each byte the master ACKs.
- R7: A read that runs past the highest subaddress keeps returning the highest register for as long as the master ACKs.
- R8: A master NACK (SDA high during the ninth clock) ends a read. SDA is released, and bytes clocked after it without a new start read 0xFF.
- R9: A stop at any point returns the target to idle, and a partly received data byte is not written. A start at any point restarts the chip-address phase.
- R10: The target changes its SDA output only while SCL is low. An ACK stays low for the whole high time of the ninth clock.
- R11: After reset `sda_oe_o` is low, no write pulse is raised, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, as seen at the pin |
| sda_i | input | 1 | Bus data line, as seen at the pin |
| addr_pins_i | input | 2 | Strap value for the two low chip-address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_en_o | output | 1 | One-cycle pulse for each accepted write byte |
| wr_addr_o | output | 16 | Subaddress of the accepted write |
| wr_data_o | output | 8 | Data of the accepted write |

## Verification
The chip-address phase is swept over every strap value against every candidate low address pair. This shows that only the exact match is acknowledged. Writes and reads run on a four-register window that straddles a high-byte carry. They start at the base, in the middle and at the top. This separates correct auto-increment from saturation at the top for reads and from refusal at the top for writes. Subaddresses just below the window, just above it and far away check that the window is decoded on all 16 bits. Stops and starts injected in the middle of a byte, a NACKed read followed by more clocks, and a check of SDA during every SCL high period cover the error paths and the bus timing.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_SUB_HI, ST_SUB_LO, ST_WDATA, ST_NINTH, ST_RDATA, ST_MACK
  } link_st_e;
endpackage

// File: rtl/i2c_pin_sync.sv
`timescale 1ns/1ps
module i2c_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // bus conditions: SDA moves while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned IW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [NUM_REGS*DW-1:0] flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && widx_i == IW'(g)) q <= wdata_i;
    end
    assign flat[g*DW +: DW] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ridx_i == IW'(i)) rdata_o = flat[i*DW +: DW];
  end
endmodule

// File: rtl/i2c_link_fsm.sv
`timescale 1ns/1ps
module i2c_link_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [4:0]  DEV_HI    = 5'b01110,
  parameter logic [15:0] BASE_ADDR = 16'h4000,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned IW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    pins_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [15:0]   wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [IW-1:0] rd_idx_o,
  output link_st_e      state_o
);
  localparam logic [16:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [16:0] WIN_HI = WIN_LO + 17'(NUM_REGS);
  localparam logic [15:0] LAST   = 16'(WIN_HI - 17'd1);

  function automatic logic in_win(input logic [15:0] a);
    return ({1'b0, a} >= WIN_LO) && ({1'b0, a} < WIN_HI);
  endfunction

  link_st_e    st, nxt;
  logic [7:0]  shreg, sub_hi;
  logic [3:0]  bit_cnt;
  logic [15:0] ptr, rd_addr;

  // reads clamp to the top register
  assign rd_addr  = in_win(ptr) ? ptr : LAST;
  assign rd_idx_o = IW'(rd_addr - BASE_ADDR);
  assign state_o  = st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      shreg     <= '0;
      sub_hi    <= '0;
      bit_cnt   <= '0;
      ptr       <= BASE_ADDR;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
        bit_cnt  <= '0;
      end else if (start_i) begin
        st       <= ST_DEV;
        sda_oe_o <= 1'b0;
        bit_cnt  <= '0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_DEV, ST_SUB_HI, ST_SUB_LO, ST_WDATA: begin
            if (scl_rise_i && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              st      <= ST_IDLE;
              unique case (st)
                ST_DEV: if (shreg[7:1] == {DEV_HI, pins_i}) begin
                  sda_oe_o <= 1'b1;
                  st       <= ST_NINTH;
                  nxt      <= shreg[0] ? ST_RDATA : ST_SUB_HI;
                end
                ST_SUB_HI: begin
                  sub_hi   <= shreg;
                  sda_oe_o <= 1'b1;
                  st       <= ST_NINTH;
                  nxt      <= ST_SUB_LO;
                end
                ST_SUB_LO: if (in_win({sub_hi, shreg})) begin
                  ptr      <= {sub_hi, shreg};
                  sda_oe_o <= 1'b1;
                  st       <= ST_NINTH;
                  nxt      <= ST_WDATA;
                end
                default: if (in_win(ptr)) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= IW'(ptr - BASE_ADDR);
                  wr_addr_o <= ptr;
                  wr_data_o <= shreg;
                  ptr       <= ptr + 16'd1;
                  sda_oe_o  <= 1'b1;
                  st        <= ST_NINTH;
                  nxt       <= ST_WDATA;
                end
              endcase
            end
          end
          ST_NINTH: if (scl_fall_i) begin
            st       <= nxt;
            bit_cnt  <= '0;
            sda_oe_o <= 1'b0;
            if (nxt == ST_RDATA) begin
              shreg    <= rdata_i;
              sda_oe_o <= ~rdata_i[7];
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) bit_cnt <= bit_cnt + 4'd1;
            if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                st       <= ST_MACK;
                bit_cnt  <= '0;
              end else if (bit_cnt != 4'd0) begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          end
          ST_MACK: if (scl_rise_i) begin
            if (!sda_s_i) begin
              if (ptr != LAST) ptr <= ptr + 16'd1;
              nxt <= ST_RDATA;
              st  <= ST_NINTH;
            end else begin
              st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [4:0]  DEV_ADDR_HI = 5'b01110,
  parameter logic [15:0] BASE_ADDR   = 16'h4000,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_pins_i,
  output logic        sda_oe_o,
  output logic        wr_en_o,
  output logic [15:0] wr_addr_o,
  output logic [7:0]  wr_data_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] rdata;
  link_st_e link_state;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_link_fsm #(
    .DEV_HI(DEV_ADDR_HI), .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .IW(IDX_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .pins_i(addr_pins_i), .rdata_i(rdata),
    .sda_oe_o, .wr_en_o, .wr_idx_o(wr_idx),
    .wr_addr_o, .wr_data_o, .rd_idx_o(rd_idx),
    .state_o(link_state)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DW(8), .IW(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(wr_en_o), .widx_i(wr_idx), .wdata_i(wr_data_o),
    .ridx_i(rd_idx), .rdata_o(rdata)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
`timescale 1ns/1ps
module i2c_reg_slave_chk
  import i2c_slv_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h4000,
  parameter int unsigned NUM_REGS  = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        start_det,
  input logic        stop_det,
  input link_st_e    state,
  input logic        sda_oe_o,
  input logic        wr_en_o,
  input logic [15:0] wr_addr_o
);
  localparam logic [16:0] LO = {1'b0, BASE_ADDR};
  localparam logic [16:0] HI = LO + 17'(NUM_REGS);

  p_wr_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ({1'b0, wr_addr_o} >= LO && {1'b0, wr_addr_o} < HI));

  p_wr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> state == ST_IDLE);

  p_start_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state == ST_DEV);

  p_idle_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> !sda_oe_o);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i, .rst_ni, .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .state(link_state), .sda_oe_o, .wr_en_o, .wr_addr_o
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QP = 10 * CLK_PERIOD;
  localparam logic [4:0]  DEV_HI = 5'b01110;
  localparam logic [15:0] BASE = 16'h40FE;
  localparam int NREG = 4;
  localparam logic [15:0] LAST = BASE + 16'(NREG - 1);

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [1:0] pins = 2'b10;
  logic sda_bus, oe, wr_en;
  logic [15:0] wr_addr;
  logic [7:0] wr_data;
  assign sda_bus = sda_m & ~oe;

  i2c_reg_slave #(.DEV_ADDR_HI(DEV_HI), .BASE_ADDR(BASE), .NUM_REGS(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_pins_i(pins), .sda_oe_o(oe), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, wr_cnt = 0, held_bad = 0, oe_hi_err = 0;
  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  logic [7:0]  model [NREG];
  logic [7:0]  rbuf [8];
  logic scl_q = 1, oe_q = 0;

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (wr_cnt < 64) begin log_a[wr_cnt] = wr_addr; log_d[wr_cnt] = wr_data; end
      wr_cnt++;
    end
    if (rst_n && scl && scl_q && oe != oe_q) oe_hi_err++;
    scl_q = scl;
    oe_q  = oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(((seed * 31 + k * 77 + 5) ^ 8'hA5));
  endfunction

  task automatic i2c_start();
    sda_m = 1; #(QP); scl = 1; #(QP); sda_m = 0; #(QP); scl = 0; #(QP);
  endtask

  task automatic i2c_stop();
    sda_m = 0; #(QP); scl = 1; #(QP); sda_m = 1; #(QP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; #(QP); scl = 1; #(2*QP); scl = 0; #(QP);
    end
  endtask

  // R10: ACK sampled early and late in the ninth high period
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    send_bits(b, 8);
    sda_m = 1; #(QP); scl = 1; #(QP/2); a1 = ~sda_bus; #(QP); a2 = ~sda_bus;
    #(QP/2); scl = 0; #(QP);
    if (a1 != a2) held_bad++;
    ack = a1;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #(QP); scl = 1; #(QP); b[i] = sda_bus; #(QP); scl = 0;
    end
    #(QP/2); sda_m = ~mack; #(QP/2); scl = 1; #(2*QP); scl = 0; #(QP); sda_m = 1;
  endtask

  task automatic head(input logic [15:0] sub, inout int mask);
    logic a;
    i2c_start();
    send_byte({DEV_HI, pins, 1'b0}, a); if (a) mask |= 1;
    send_byte(sub[15:8], a); if (a) mask |= 2;
    send_byte(sub[7:0], a);  if (a) mask |= 4;
  endtask

  task automatic do_write(input logic [15:0] sub, input int n, input int seed, output int mask);
    logic a;
    mask = 0;
    head(sub, mask);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(seed, k), a);
      if (a) mask |= (1 << (3 + k));
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [15:0] sub, input int n, output int mask);
    logic a;
    mask = 0;
    head(sub, mask);
    i2c_start();
    send_byte({DEV_HI, pins, 1'b1}, a); if (a) mask |= 8;
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k < n - 1);
    i2c_stop();
  endtask

  task automatic read_check(input string tag, input logic [15:0] sub, input int n);
    int m, s;
    do_read(sub, n, m);
    chk({tag, " read acks"}, m, 'hF);
    s = int'(sub - BASE);
    for (int k = 0; k < n; k++)
      chk({tag, " read data"}, rbuf[k], model[(s + k) > NREG - 1 ? NREG - 1 : s + k]);
  endtask

  initial begin
    int m, w0;
    logic a;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R11 oe after reset", oe, 0);
    chk("R11 no write after reset", wr_cnt, 0);
    read_check("R11 registers zero", BASE, NREG);

    // R1: all straps against all low-bit pairs
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        pins = 2'(p);
        i2c_start();
        send_byte({DEV_HI, 2'(q), 1'b0}, a);
        i2c_stop();
        chk($sformatf("R1 address match pins=%0d q=%0d", p, q), a, p == q);
      end
    end
    pins = 2'b10;

    // R2 R3: burst across the high-byte carry
    w0 = wr_cnt;
    do_write(BASE, NREG, 1, m);
    chk("R2 write acks", m, 'h7F);
    chk("R2 write pulses", wr_cnt - w0, NREG);
    for (int k = 0; k < NREG; k++) begin
      chk("R3 write address", log_a[w0 + k], BASE + 16'(k));
      chk("R2 write data", log_d[w0 + k], pat(1, k));
      model[k] = pat(1, k);
    end

    read_check("R6 full read", BASE, NREG);
    read_check("R6 mid read", BASE + 16'd1, 2);
    read_check("R7 read past top", LAST, 4);

    // R5: write crosses the top
    w0 = wr_cnt;
    do_write(BASE + 16'd2, 3, 2, m);
    chk("R5 write acks at top", m, 'h1F);
    chk("R5 pulses at top", wr_cnt - w0, 2);
    model[2] = pat(2, 0);
    model[3] = pat(2, 1);
    read_check("R5 contents after top", BASE, NREG);

    // R4: subaddresses outside the window
    foreach (rbuf[i]) rbuf[i] = '0;
    for (int j = 0; j < 5; j++) begin
      logic [15:0] sub;
      case (j)
        0: sub = BASE - 16'd1;
        1: sub = BASE + 16'(NREG);
        2: sub = 16'h00FE;
        3: sub = 16'hC0FE;
        default: sub = 16'h41FF;
      endcase
      w0 = wr_cnt;
      do_write(sub, 1, 3, m);
      chk($sformatf("R4 nack sub %0h", sub), m, 'h3);
      chk("R4 no write", wr_cnt - w0, 0);
    end
    w0 = wr_cnt;
    do_write(LAST, 1, 4, m);
    chk("R4 top edge accepted", m, 'hF);
    chk("R4 top edge write", wr_cnt - w0, 1);
    model[3] = pat(4, 0);

    // R9: stop inside a data byte
    w0 = wr_cnt;
    m = 0;
    head(BASE, m);
    send_bits(8'h3C, 4);
    i2c_stop();
    chk("R9 head acked", m, 'h7);
    chk("R9 partial byte dropped", wr_cnt - w0, 0);
    // R9: start inside a byte restarts addressing
    m = 0;
    head(LAST, m);
    send_bits(8'hF0, 3);
    head(BASE + 16'd1, m);
    send_byte(pat(5, 0), a);
    i2c_stop();
    chk("R9 restart write ack", a, 1);
    chk("R9 restart one write", wr_cnt - w0, 1);
    chk("R9 restart address", log_a[w0], BASE + 16'd1);
    model[1] = pat(5, 0);
    read_check("R9 contents", BASE, NREG);

    // R8: NACK ends the read
    m = 0;
    head(BASE, m);
    i2c_start();
    send_byte({DEV_HI, pins, 1'b1}, a);
    recv_byte(b, 1'b0);
    chk("R8 single byte", b, model[0]);
    chk("R8 released after nack", oe, 0);
    recv_byte(b, 1'b0);
    chk("R8 no data after nack", b, 'hFF);
    i2c_stop();

    chk("R10 ack held through ninth high", held_bad, 0);
    chk("R10 sda steady while scl high", oe_hi_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule